// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's bit-level receiver and transmitter, its two byte FIFOs and the host's data-register port. A two-bit channel mode decides where each byte goes. In normal operation serial input fills the receive FIFO and host writes fill the transmit FIFO. In automatic echo every received byte also goes back out. Local loopback feeds host writes straight into the receive FIFO. Remote loopback returns serial input to the line without the host seeing it.

Independent enable and disable bits gate each direction, and a disable bit overrides its enable bit. Two self-clearing control bits empty the FIFOs. The block reports receive overrun and raises a receive-timeout pulse four character times after the last stored byte. It also tells the receiver how many more bytes it may deliver. A small host register port sets the control word, the channel mode and the timeout setting, and pops received bytes.

Top module: `uart_chan_router`

## Requirements
- R1: A host write to address 1 takes the channel mode from `host_wdata[9:8]` (0 normal, 1 echo, 2 local loopback, 3 remote loopback). A serial byte goes to the receive FIFO in modes 0 and 1, to the transmit FIFO in modes 1 and 3, and is discarded in mode 2.
- R2: A host write to address 2 carries a byte in `host_wdata[7:0]`. That byte goes to the transmit FIFO in mode 0 and to the receive FIFO in mode 2, and is dropped in modes 1 and 3.
- R3: The receive direction is active only while control bit 2 is 1 and control bit 3 is 0. While it is inactive, nothing is stored into the receive FIFO and data reads pop nothing.
- R4: The transmit direction is active only while control bit 4 is 1 and control bit 5 is 0. A byte routed to a full transmit FIFO is dropped and raises no flag.
- R5: A control write (address 0) with bit 0 set empties the receive FIFO, and one with bit 1 set empties the transmit FIFO, by the next cycle. An empty takes priority over a store in the same cycle. Both bits always read back as 0.
- R6: A byte routed to a full receive FIFO is discarded, the FIFO level is unchanged, and `rx_overrun` pulses for one cycle.
- R7: `accept_room` starts from the larger FIFO depth. It is limited by the free receive space in modes 0 and 1 and by the free transmit space in modes 1 and 3.
- R8: `rx_timeout` pulses `4*CHAR_CYCLES` cycles after the last byte stored in the receive FIFO, and only when the timeout setting (address 3, bits 7:0) is nonzero at that time.
- R9: After reset the control word reads 0x128 (both directions disabled, stop-break bit 8 set), the mode and timeout setting read 0, and both FIFOs are empty.
- R10: A host read returns data on `host_rdata` in the next cycle. At address 2 it pops the receive FIFO in arrival order. When that FIFO is empty or the receive direction is inactive, it returns 0 and the level is unchanged.
- R11: `ser_tx_valid` is high while the transmit FIFO holds a byte, and `ser_tx_data` shows the oldest byte. A cycle with `ser_tx_ready` high removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 2 | 0 control, 1 mode, 2 data, 3 timeout setting |
| host_wdata | input | HW | Host write data |
| host_rdata | output | HW | Host read data, valid the cycle after `host_re` |
| ser_rx_valid | input | 1 | Byte from serial receiver |
| ser_rx_data | input | DW | Received byte |
| ser_tx_valid | output | 1 | Transmit FIFO holds a byte |
| ser_tx_data | output | DW | Oldest transmit byte |
| ser_tx_ready | input | 1 | Transmitter takes the byte |
| rx_level | output | RLW | Receive FIFO fill level |
| tx_level | output | TLW | Transmit FIFO fill level |
| accept_room | output | AW | Bytes the receiver may still deliver |
| rx_overrun | output | 1 | One-cycle overrun pulse |
| rx_timeout | output | 1 | One-cycle receive-timeout pulse |

## Verification
FIFO levels, the overrun pulse and read data are all registered, so each shows the effect of a stimulus one clock edge later. `accept_room` and the transmit head follow combinationally from the registered levels and mode, so they are due in the same cycle as the new levels. The timeout pulse is due on the edge exactly `4*CHAR_CYCLES` edges after the storing edge. The bench applies each stimulus at a falling edge, lets one rising edge pass, and compares every output with its model at the following falling edge. Its timeout expectation counts those same steps.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;

   typedef enum logic [1:0] {
      CH_NORMAL = 2'd0,
      CH_ECHO   = 2'd1,
      CH_LOCAL  = 2'd2,
      CH_REMOTE = 2'd3
   } chan_mode_e;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_MODE = 2'd1,
      A_DATA = 2'd2,
      A_TMO  = 2'd3
   } host_addr_e;

   localparam int          CTRL_W    = 9;
   localparam logic [8:0]  CTRL_INIT = 9'h128;
   localparam int          B_RXFLUSH = 0;
   localparam int          B_TXFLUSH = 1;
   localparam int          B_RXON    = 2;
   localparam int          B_RXOFF   = 3;
   localparam int          B_TXON    = 4;
   localparam int          B_TXOFF   = 5;
   localparam int          MODE_LSB  = 8;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/uart_rt_fifo.sv
module uart_rt_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rt_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rptr, wptr, rnext, wnext;
   logic          do_push, do_pop;

   assign do_push = push && (level != LW'(DEPTH));
   assign do_pop  = pop  && (level != '0);
   assign dout    = mem[rptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wnext = wptr + 1'b1;
      assign rnext = rptr + 1'b1;
   end else begin : g_wrap
      assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rptr  <= '0;
         wptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R6: the router only stores into a FIFO that has room
   assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (level != LW'(DEPTH)));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

endmodule

// File: rtl/uart_rt_regs.sv
module uart_rt_regs
   import uart_rt_pkg::*;
#(
   parameter int HW = 16,
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [1:0]    host_addr,
   input  logic [HW-1:0] host_wdata,
   output chan_mode_e    mode,
   output logic          rx_en,
   output logic          tx_en,
   output logic          rx_flush,
   output logic          tx_flush,
   output logic [TW-1:0] tmo_cfg,
   output logic [HW-1:0] reg_rdata
);

   logic [CTRL_W-1:0] ctrl_q;
   host_addr_e        sel;
   logic              wr_ctrl, wr_mode, wr_tmo;
   logic              unused_wdata;

   assign sel     = host_addr_e'(host_addr);
   assign wr_ctrl = host_we && (sel == A_CTRL);
   assign wr_mode = host_we && (sel == A_MODE);
   assign wr_tmo  = host_we && (sel == A_TMO);
   assign unused_wdata = &{1'b0, host_wdata[HW-1:MODE_LSB+2]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_INIT;
         mode    <= CH_NORMAL;
         tmo_cfg <= '0;
      end else begin
         if (wr_ctrl) ctrl_q  <= {host_wdata[CTRL_W-1:B_RXON], 2'b00};
         if (wr_mode) mode    <= chan_mode_e'(host_wdata[MODE_LSB+1:MODE_LSB]);
         if (wr_tmo)  tmo_cfg <= host_wdata[TW-1:0];
      end
   end

   // disable wins over enable in each direction
   assign rx_en    = ctrl_q[B_RXON] && !ctrl_q[B_RXOFF];
   assign tx_en    = ctrl_q[B_TXON] && !ctrl_q[B_TXOFF];
   assign rx_flush = wr_ctrl && host_wdata[B_RXFLUSH];
   assign tx_flush = wr_ctrl && host_wdata[B_TXFLUSH];

   always_comb begin
      case (sel)
         A_CTRL:  reg_rdata = HW'(ctrl_q);
         A_MODE:  reg_rdata = HW'({mode, 8'h00});
         A_TMO:   reg_rdata = HW'(tmo_cfg);
         default: reg_rdata = '0;
      endcase
   end

   // R1: the mode changes only through a mode write
   assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(mode));

   // R5: the flush bits never read back as set
   assert_flush_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (reg_rdata[1:0] == 2'b00) || (sel != A_CTRL));

endmodule

// File: rtl/uart_rt_route.sv
module uart_rt_route
   import uart_rt_pkg::*;
#(
   parameter  int DW  = 8,
   parameter  int RXD = 16,
   parameter  int TXD = 16,
   localparam int RLW = $clog2(RXD + 1),
   localparam int TLW = $clog2(TXD + 1),
   localparam int MAXD = imax(RXD, TXD),
   localparam int AW  = $clog2(MAXD + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  chan_mode_e     mode,
   input  logic           rx_en,
   input  logic           tx_en,
   input  logic           ser_valid,
   input  logic [DW-1:0]  ser_data,
   input  logic           host_dwe,
   input  logic [DW-1:0]  host_byte,
   input  logic [RLW-1:0] rx_level,
   input  logic [TLW-1:0] tx_level,
   output logic           rx_push,
   output logic [DW-1:0]  rx_din,
   output logic           tx_push,
   output logic [DW-1:0]  tx_din,
   output logic           rx_ovr,
   output logic [AW-1:0]  room
);

   logic ser_to_rx, ser_to_tx, host_to_rx, host_to_tx;
   logic rx_req, tx_req, rx_full, tx_full;
   logic [AW-1:0] rx_free, tx_free;

   assign ser_to_rx  = (mode == CH_NORMAL) || (mode == CH_ECHO);
   assign ser_to_tx  = (mode == CH_ECHO)   || (mode == CH_REMOTE);
   assign host_to_rx = (mode == CH_LOCAL);
   assign host_to_tx = (mode == CH_NORMAL);

   assign rx_full = (rx_level == RLW'(RXD));
   assign tx_full = (tx_level == TLW'(TXD));

   assign rx_req  = rx_en && ((ser_valid && ser_to_rx) || (host_dwe && host_to_rx));
   assign tx_req  = tx_en && ((ser_valid && ser_to_tx) || (host_dwe && host_to_tx));
   assign rx_din  = host_to_rx ? host_byte : ser_data;
   assign tx_din  = host_to_tx ? host_byte : ser_data;

   assign rx_push = rx_req && !rx_full;
   assign rx_ovr  = rx_req && rx_full;
   assign tx_push = tx_req && !tx_full;

   assign rx_free = AW'(RXD) - AW'(rx_level);
   assign tx_free = AW'(TXD) - AW'(tx_level);

   always_comb begin
      room = AW'(MAXD);
      if (ser_to_rx && (rx_free < room)) room = rx_free;
      if (ser_to_tx && (tx_free < room)) room = tx_free;
   end

   // R2: a host byte never lands in both FIFOs
   assert_host_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_dwe && !ser_valid) |-> !(rx_push && tx_push));

   // R7: room never promises more than a limiting FIFO holds
   assert_room_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ser_to_rx |-> (room <= rx_free));

endmodule

// File: rtl/uart_rt_tmo.sv
module uart_rt_tmo #(
   parameter  int TW        = 8,
   parameter  int CHAR_CYC  = 10,
   localparam int WAIT      = 4 * CHAR_CYC,
   localparam int CW        = $clog2(WAIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] tmo_cfg,
   output logic          fire
);

   if (CHAR_CYC < 1) begin : g_bad_char
      $error("uart_rt_tmo: CHAR_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         fire <= 1'b0;
      end else begin
         if (load)             cnt <= CW'(WAIT);
         else if (cnt != '0)   cnt <= cnt - 1'b1;
         fire <= (cnt == CW'(1)) && (tmo_cfg != '0);
      end
   end

   // R8: no timeout pulse while the setting is zero
   assert_tmo_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> ($past(tmo_cfg) != '0));

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
   import uart_rt_pkg::*;
#(
   parameter  int DW          = 8,
   parameter  int RX_DEPTH    = 16,
   parameter  int TX_DEPTH    = 16,
   parameter  int HW          = 16,
   parameter  int TMO_W       = 8,
   parameter  int CHAR_CYCLES = 10,
   localparam int RLW         = $clog2(RX_DEPTH + 1),
   localparam int TLW         = $clog2(TX_DEPTH + 1),
   localparam int AW          = $clog2(imax(RX_DEPTH, TX_DEPTH) + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           host_we,
   input  logic           host_re,
   input  logic [1:0]     host_addr,
   input  logic [HW-1:0]  host_wdata,
   output logic [HW-1:0]  host_rdata,
   input  logic           ser_rx_valid,
   input  logic [DW-1:0]  ser_rx_data,
   output logic           ser_tx_valid,
   output logic [DW-1:0]  ser_tx_data,
   input  logic           ser_tx_ready,
   output logic [RLW-1:0] rx_level,
   output logic [TLW-1:0] tx_level,
   output logic [AW-1:0]  accept_room,
   output logic           rx_overrun,
   output logic           rx_timeout
);

   if (HW < MODE_LSB + 2) begin : g_bad_hw
      $error("uart_chan_router: HW too narrow for the mode field");
   end
   if ((DW > HW) || (TMO_W > HW)) begin : g_bad_fields
      $error("uart_chan_router: DW and TMO_W must fit in HW");
   end

   chan_mode_e       mode;
   logic             rx_en, tx_en, rx_flush, tx_flush;
   logic [TMO_W-1:0] tmo_cfg;
   logic [HW-1:0]    reg_rdata;
   logic             host_dwe, rd_data;
   logic             rx_push, tx_push, rx_pop, tx_pop, rx_ovr;
   logic [DW-1:0]    rx_din, tx_din, rx_head;

   assign host_dwe = host_we && (host_addr_e'(host_addr) == A_DATA);
   assign rd_data  = host_re && (host_addr_e'(host_addr) == A_DATA);

   uart_rt_regs #(.HW(HW), .TW(TMO_W)) u_regs (
      .clk, .rst_n, .host_we, .host_addr, .host_wdata,
      .mode, .rx_en, .tx_en, .rx_flush, .tx_flush, .tmo_cfg, .reg_rdata
   );

   uart_rt_route #(.DW(DW), .RXD(RX_DEPTH), .TXD(TX_DEPTH)) u_route (
      .clk, .rst_n, .mode, .rx_en, .tx_en,
      .ser_valid (ser_rx_valid),
      .ser_data  (ser_rx_data),
      .host_dwe,
      .host_byte (host_wdata[DW-1:0]),
      .rx_level, .tx_level,
      .rx_push, .rx_din, .tx_push, .tx_din, .rx_ovr,
      .room      (accept_room)
   );

   assign rx_pop = rd_data && rx_en && (rx_level != '0);
   assign tx_pop = ser_tx_ready && (tx_level != '0);

   uart_rt_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
      .clk, .rst_n, .flush(rx_flush), .push(rx_push), .din(rx_din),
      .pop(rx_pop), .dout(rx_head), .level(rx_level)
   );

   uart_rt_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
      .clk, .rst_n, .flush(tx_flush), .push(tx_push), .din(tx_din),
      .pop(tx_pop), .dout(ser_tx_data), .level(tx_level)
   );

   assign ser_tx_valid = (tx_level != '0);

   uart_rt_tmo #(.TW(TMO_W), .CHAR_CYC(CHAR_CYCLES)) u_tmo (
      .clk, .rst_n,
      .load    (rx_push && !rx_flush),
      .tmo_cfg,
      .fire    (rx_timeout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
         rx_overrun <= 1'b0;
      end else begin
         rx_overrun <= rx_ovr;
         if (host_re) begin
            if (rd_data) host_rdata <= rx_pop ? HW'(rx_head) : '0;
            else         host_rdata <= reg_rdata;
         end
      end
   end

   assert_rx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (rx_level == '0));

   assert_tx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (tx_level == '0));

   assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (rx_level <= $past(rx_level)));

   assert_tx_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_flush) |=> (tx_level <= $past(tx_level)));

   assert_ovr_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> ($past(rx_level) == RLW'(RX_DEPTH)));

   assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && (rx_level == '0)) |=> (host_rdata == '0));

endmodule

// File: tb/sim_uart_chan_router.sv
`timescale 1ns/1ps
module sim_uart_chan_router;

   localparam int RXD  = 16;
   localparam int TXD  = 16;
   localparam int CHC  = 10;
   localparam int WAIT = 4 * CHC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0, host_re = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        ser_rx_valid = 1'b0;
   logic [7:0]  ser_rx_data = '0;
   logic        ser_tx_valid;
   logic [7:0]  ser_tx_data;
   logic        ser_tx_ready = 1'b0;
   logic [4:0]  rx_level, tx_level, accept_room;
   logic        rx_overrun, rx_timeout;

   uart_chan_router #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .CHAR_CYCLES(CHC)) u0 (
      .clk, .rst_n, .host_we, .host_re, .host_addr, .host_wdata, .host_rdata,
      .ser_rx_valid, .ser_rx_data, .ser_tx_valid, .ser_tx_data, .ser_tx_ready,
      .rx_level, .tx_level, .accept_room, .rx_overrun, .rx_timeout
   );

   always #4 clk = ~clk;

   int n_run = 0, n_fail = 0, cyc = 0, last_push = -100000, wd = 0;
   logic [7:0] rxq[$];
   logic [7:0] txq[$];
   logic [8:0] m_ctrl = 9'h128;
   logic [1:0] m_mode = 2'd0;
   logic [7:0] m_tmo  = 8'd0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int room_of(input logic [1:0] m, input int rl, input int tl);
      int r = (RXD > TXD) ? RXD : TXD;
      if ((m == 2'd0 || m == 2'd1) && (RXD - rl) < r) r = RXD - rl;
      if ((m == 2'd1 || m == 2'd3) && (TXD - tl) < r) r = TXD - tl;
      return r;
   endfunction

   task automatic step(input logic we, input logic [1:0] a, input logic [15:0] wdat,
                       input logic re, input logic sv, input logic [7:0] sd,
                       input logic tr);
      logic rxen, txen, frx, ftx, dwe, ovr, fire, rxreq, txreq;
      logic [7:0] rb, tb;
      logic [15:0] erd;
      int rxpre, txpre;
      host_we = we; host_addr = a; host_wdata = wdat; host_re = re;
      ser_rx_valid = sv; ser_rx_data = sd; ser_tx_ready = tr;
      rxen  = m_ctrl[2] && !m_ctrl[3];
      txen  = m_ctrl[4] && !m_ctrl[5];
      frx   = we && a == 2'd0 && wdat[0];
      ftx   = we && a == 2'd0 && wdat[1];
      dwe   = we && a == 2'd2;
      rxpre = rxq.size();
      txpre = txq.size();
      fire  = (cyc - last_push == WAIT) && (m_tmo != 0);
      erd   = '0;
      if (re) begin
         case (a)
            2'd0: erd = 16'(m_ctrl);
            2'd1: erd = 16'({m_mode, 8'h00});
            2'd2: if (rxen && rxpre > 0) erd = 16'(rxq.pop_front());
            default: erd = 16'(m_tmo);
         endcase
      end
      if (tr && txpre > 0) void'(txq.pop_front());
      rxreq = rxen && ((sv && (m_mode == 0 || m_mode == 1)) || (dwe && m_mode == 2));
      txreq = txen && ((sv && (m_mode == 1 || m_mode == 3)) || (dwe && m_mode == 0));
      rb = (m_mode == 2) ? wdat[7:0] : sd;
      tb = (m_mode == 0) ? wdat[7:0] : sd;
      ovr = 1'b0;
      if (rxreq) begin
         if (rxpre == RXD) ovr = 1'b1;
         else if (!frx) begin rxq.push_back(rb); last_push = cyc; end
      end
      if (txreq && txpre < TXD && !ftx) txq.push_back(tb);
      if (frx) rxq.delete();
      if (ftx) txq.delete();
      if (we && a == 2'd0) m_ctrl = {wdat[8:2], 2'b00};
      if (we && a == 2'd1) m_mode = wdat[9:8];
      if (we && a == 2'd3) m_tmo  = wdat[7:0];
      cyc++;
      @(posedge clk);
      @(negedge clk);
      chk("R1 rx_level", 32'(rx_level), 32'(rxq.size()));
      chk("R2 tx_level", 32'(tx_level), 32'(txq.size()));
      chk("R6 rx_overrun", 32'(rx_overrun), 32'(ovr));
      chk("R8 rx_timeout", 32'(rx_timeout), 32'(fire));
      chk("R7 accept_room", 32'(accept_room), 32'(room_of(m_mode, rxq.size(), txq.size())));
      chk("R11 ser_tx_valid", 32'(ser_tx_valid), 32'(txq.size() > 0));
      if (txq.size() > 0) chk("R11 ser_tx_data", 32'(ser_tx_data), 32'(txq[0]));
      if (re) chk("R10 host_rdata", 32'(host_rdata), 32'(erd));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk("R9 rx_level", 32'(rx_level), 0);
      chk("R9 tx_level", 32'(tx_level), 0);
      chk("R9 accept_room", 32'(accept_room), RXD);
      step(0, 2'd0, 0, 1, 0, 0, 0);
      chk("R9 ctrl reset", 32'(host_rdata), 32'h128);
      step(0, 2'd1, 0, 1, 0, 0, 0);
      chk("R9 mode reset", 32'(host_rdata), 0);
      step(0, 2'd3, 0, 1, 0, 0, 0);
      chk("R9 tmo reset", 32'(host_rdata), 0);
      // R3 / R4 with both paths disabled
      step(0, 0, 0, 0, 1, 8'h5A, 0);
      chk("R3 disabled rx keeps level", 32'(rx_level), 0);
      step(1, 2'd2, 16'h00A5, 0, 0, 0, 0);
      chk("R4 disabled tx keeps level", 32'(tx_level), 0);
      // enable both, fill rx past full in normal mode
      step(1, 2'd0, 16'h0014, 0, 0, 0, 0);
      for (int i = 0; i < RXD; i++) step(0, 0, 0, 0, 1, 8'(i + 8'h30), 0);
      chk("R7 room zero when rx full", 32'(accept_room), 0);
      step(0, 0, 0, 0, 1, 8'hEE, 0);
      chk("R6 overrun pulse", 32'(rx_overrun), 1);
      chk("R6 level held", 32'(rx_level), RXD);
      step(0, 2'd2, 0, 1, 0, 0, 0);
      chk("R10 first byte", 32'(host_rdata), 32'h30);
      step(0, 2'd2, 0, 1, 0, 0, 0);
      // R5 flush with concurrent serial byte
      step(1, 2'd0, 16'h0015, 0, 1, 8'h77, 0);
      chk("R5 rx emptied", 32'(rx_level), 0);
      step(0, 2'd0, 0, 1, 0, 0, 0);
      chk("R5 self-clear readback", 32'(host_rdata), 32'h014);
      step(0, 2'd2, 0, 1, 0, 0, 0);
      chk("R10 empty read zero", 32'(host_rdata), 0);
      // normal host writes to tx, then tx flush
      step(1, 2'd2, 16'h00C1, 0, 0, 0, 0);
      step(1, 2'd2, 16'h00C2, 0, 0, 0, 0);
      chk("R2 host to tx", 32'(tx_level), 2);
      step(1, 2'd0, 16'h0016, 0, 0, 0, 0);
      chk("R5 tx emptied", 32'(tx_level), 0);
      // R8 timeout with nonzero and zero setting
      step(1, 2'd3, 16'h0003, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h11, 0);
      idle(WAIT + 3);
      step(1, 2'd3, 16'h0000, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 8'h12, 0);
      idle(WAIT + 3);
      // modes: echo, local, remote
      for (int m = 1; m < 4; m++) begin
         step(1, 2'd1, 16'(m << 8), 0, 0, 0, 0);
         step(0, 0, 0, 0, 1, 8'(8'h40 + m), 0);
         step(1, 2'd2, 16'(8'h50 + m), 0, 0, 0, 0);
         step(0, 0, 0, 0, 0, 0, 1);
      end
      // R4: tx disable overrides enable in normal mode
      step(1, 2'd1, 16'h0000, 0, 0, 0, 0);
      step(1, 2'd0, 16'h0037, 0, 0, 0, 0);
      step(1, 2'd2, 16'h0099, 0, 0, 0, 0);
      chk("R4 disable wins", 32'(tx_level), 0);
      step(1, 2'd0, 16'h0014, 0, 0, 0, 0);
      // constrained random
      for (int i = 0; i < 6000; i++) begin
         int r;
         logic we, re, sv, tr;
         logic [1:0] a;
         logic [15:0] wv;
         r  = $urandom % 16;
         we = 0; re = 0; a = 0; wv = 16'($urandom);
         sv = ($urandom % 2) == 0;
         tr = ($urandom % 3) == 0;
         if (r == 0) begin
            we = 1; a = 2'd0;
            wv = 16'h0014 | (($urandom % 8 == 0) ? 16'h0008 : 16'h0)
                          | (($urandom % 8 == 0) ? 16'h0020 : 16'h0)
                          | (($urandom % 10 == 0) ? 16'h0001 : 16'h0)
                          | (($urandom % 10 == 0) ? 16'h0002 : 16'h0);
         end else if (r == 1) begin
            we = 1; a = 2'd1;
         end else if (r == 2) begin
            we = 1; a = 2'd3; wv = 16'($urandom % 4);
         end else if (r < 7) begin
            we = 1; a = 2'd2;
         end else if (r < 11) begin
            re = 1; a = (($urandom % 4) == 0) ? 2'($urandom) : 2'd2;
         end
         step(we, a, wv, re, sv, 8'($urandom), tr);
      end
      idle(2);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule